// File: doc/BRIEF.md
# Sorted Block Compare-Split Unit

This unit is one partner's half of a block compare-split step in a parallel sort. Both inputs are ascending blocks of K unsigned keys, each W bits wide. One block is the partner's own keys and the other is the block received from its peer. The unit merges the two blocks one key per clock cycle and keeps only the half it owns. The low partner keeps the K smallest keys of the merged sequence. The high partner keeps the K largest keys. When both partners run with opposite roles, they end up holding two disjoint ascending halves of the combined 2K keys.

A one-cycle start strobe captures both key vectors and the role. The walk runs for exactly K cycles. In low role it consumes keys from the small end of both blocks. In high role it consumes keys from the large end. A done strobe marks the cycle in which the result vector is complete. The result then holds until another start is accepted. A start that arrives during a walk is dropped.

Top module: `compare_split`

## Requirements
- R1: The `local_i` and `recv_i` inputs each carry K keys, and each key is W bits, unsigned. Slot s occupies bits [s*W +: W]. Each block is ascending from slot 0 upward. The output is a subsequence of the ascending merge of all 2K keys.
- R2: With `role_i` = 0 (low), `result_o` holds the K smallest of the 2K keys, with the smallest in slot 0 and ascending upward.
- R3: With `role_i` = 1 (high), `result_o` holds the K largest of the 2K keys, with the smallest of them in slot 0 and ascending upward.
- R4: `done_o` is high for exactly one cycle. It rises after the K-th rising edge that follows the edge which accepted `start_i`.
- R5: After `done_o`, `result_o` does not change until a new start is accepted.
- R6: A `start_i` pulse while a walk is in progress is ignored. It changes neither the result keys, nor the role used, nor the `done_o` timing.
- R7: Asynchronous active-low reset `rst_ni` clears `done_o` and `result_o` to zero and leaves the unit idle and ready to accept a start.
- R8: Equal keys, whether inside one block or across both blocks, are placed correctly. The output multiset is exactly the K lowest (or highest) keys of the merged multiset.
- R9: With K = 5, local {1,6,8,11,13} and received {2,7,9,10,12}, the low result is {1,2,6,7,8} and the high result is {9,10,11,12,13}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that captures both blocks and the role |
| role_i | input | 1 | 0 keeps the lower half, 1 keeps the upper half |
| local_i | input | K*W | Own ascending block, slot s at bits [s*W +: W] |
| recv_i | input | K*W | Peer's ascending block, same layout |
| result_o | output | K*W | Kept half, ascending, same layout |
| done_o | output | 1 | One-cycle strobe when result_o is complete |

## Verification
The main bench instance uses K = 4 and W = 2. With these values there are 35 distinct ascending blocks, so every ordered pair of blocks can be run under both roles: 2450 compare-splits. This sweep reaches every pattern of ties, every way the merge can interleave the two blocks, and the cases where one block is used up before the other. A second instance with K = 5 and W = 4 runs the worked example for R9. It covers an odd block size, where K is not a power of two and the slot index is not a full binary range. Some runs send a second start with different data part-way through the walk.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    ROLE_LOW  = 1'b0,
    ROLE_HIGH = 1'b1
  } role_e;
endpackage

// File: rtl/cs_pick.sv
// Chooses the next key of the merge walk from the heads of both blocks.
module cs_pick #(
  parameter int K  = 4,
  parameter int W  = 8,
  localparam int CW = $clog2(K + 1),
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic [K-1:0][W-1:0] loc_i,
  input  logic [K-1:0][W-1:0] rcv_i,
  input  logic [CW-1:0]       loc_used_i,
  input  logic [CW-1:0]       rcv_used_i,
  input  cs_pkg::role_e       role_i,
  output logic                take_loc_o,
  output logic [W-1:0]        key_o
);
  logic          loc_ok, rcv_ok;
  logic [CW-1:0] loc_pos, rcv_pos;
  logic [W-1:0]  loc_key, rcv_key;

  always_comb begin
    loc_ok  = loc_used_i < CW'(K);
    rcv_ok  = rcv_used_i < CW'(K);
    // high role walks from the top slot downward
    loc_pos = (role_i == cs_pkg::ROLE_HIGH) ? CW'(K - 1) - loc_used_i : loc_used_i;
    rcv_pos = (role_i == cs_pkg::ROLE_HIGH) ? CW'(K - 1) - rcv_used_i : rcv_used_i;
    loc_key = loc_ok ? loc_i[loc_pos[IW-1:0]] : '0;
    rcv_key = rcv_ok ? rcv_i[rcv_pos[IW-1:0]] : '0;
    // ties: local precedes received in the merged order
    if (!rcv_ok)
      take_loc_o = 1'b1;
    else if (!loc_ok)
      take_loc_o = 1'b0;
    else if (role_i == cs_pkg::ROLE_HIGH)
      take_loc_o = loc_key > rcv_key;
    else
      take_loc_o = loc_key <= rcv_key;
    key_o = take_loc_o ? loc_key : rcv_key;
  end
endmodule

// File: rtl/cs_ctrl.sv
// Walk sequencer: K steps per accepted start, one-cycle done.
module cs_ctrl #(
  parameter int K  = 4,
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [IW-1:0] step_o,
  output logic          done_o
);
  logic          busy_q, done_q, last;
  logic [IW-1:0] step_q;

  assign accept_o = start_i && !busy_q;
  assign last     = busy_q && (step_q == IW'(K - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (accept_o) begin
        busy_q <= 1'b1;
        step_q <= '0;
      end else if (busy_q) begin
        step_q <= step_q + 1'b1;
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
  assign done_o = done_q;
endmodule

// File: rtl/compare_split.sv
module compare_split #(
  parameter int K = 4,
  parameter int W = 8,
  localparam int CW = $clog2(K + 1),
  localparam int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         role_i,
  input  logic [K*W-1:0] local_i,
  input  logic [K*W-1:0] recv_i,
  output logic [K*W-1:0] result_o,
  output logic         done_o
);
  import cs_pkg::*;

  logic [K-1:0][W-1:0] loc_q, rcv_q, res_q;
  logic [CW-1:0]       loc_used_q, rcv_used_q;
  role_e               role_q;
  logic                accept, busy, take_loc;
  logic [IW-1:0]       step, slot;
  logic [W-1:0]        key;

  cs_ctrl #(.K(K)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .step_o   (step),
    .done_o   (done_o)
  );

  cs_pick #(.K(K), .W(W)) u_pick (
    .loc_i      (loc_q),
    .rcv_i      (rcv_q),
    .loc_used_i (loc_used_q),
    .rcv_used_i (rcv_used_q),
    .role_i     (role_q),
    .take_loc_o (take_loc),
    .key_o      (key)
  );

  assign slot = (role_q == ROLE_HIGH) ? IW'(K - 1) - step : step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loc_q      <= '0;
      rcv_q      <= '0;
      role_q     <= ROLE_LOW;
      loc_used_q <= '0;
      rcv_used_q <= '0;
    end else if (accept) begin
      loc_q      <= local_i;
      rcv_q      <= recv_i;
      role_q     <= role_e'(role_i);
      loc_used_q <= '0;
      rcv_used_q <= '0;
    end else if (busy) begin
      loc_used_q <= loc_used_q + CW'(take_loc);
      rcv_used_q <= rcv_used_q + CW'(!take_loc);
    end
  end

  for (genvar s = 0; s < K; s++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        res_q[s] <= '0;
      else if (busy && slot == IW'(s))
        res_q[s] <= key;
    end
  end

  assign result_o = res_q;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
  parameter int K = 4,
  parameter int W = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           done_o,
  input logic [K*W-1:0] result_o,
  input logic           busy,
  input logic           role_q
);
  logic ascending;
  always_comb begin
    ascending = 1'b1;
    for (int s = 1; s < K; s++)
      if (result_o[s*W +: W] < result_o[(s-1)*W +: W]) ascending = 1'b0;
  end

  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_start_only_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(start_i));

  assert_result_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !start_i) |=> $stable(result_o));

  assert_role_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(role_q));

  assert_sorted_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ascending);
endmodule

bind compare_split cs_checker #(.K(K), .W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .done_o   (done_o),
  .result_o (result_o),
  .busy     (busy),
  .role_q   (role_q)
);

// File: tb/compare_split_test.sv
`timescale 1ns/1ps
module compare_split_test;
  localparam int K = 4;
  localparam int W = 2;
  localparam int NB = 35;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0, role = 1'b0;
  logic [K*W-1:0] loc = '0, rcv = '0;
  logic [K*W-1:0] res;
  logic done;

  logic start5 = 1'b0, role5 = 1'b0;
  logic [19:0] loc5 = '0, rcv5 = '0;
  logic [19:0] res5;
  logic done5;

  int checks = 0, errors = 0, cycles = 0;
  logic [K*W-1:0] blocks [NB];

  always #2.5 clk = ~clk;

  compare_split #(.K(K), .W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .role_i(role),
    .local_i(loc), .recv_i(rcv), .result_o(res), .done_o(done));

  compare_split #(.K(5), .W(4)) uut_k5 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start5), .role_i(role5),
    .local_i(loc5), .recv_i(rcv5), .result_o(res5), .done_o(done5));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 190000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [K*W-1:0] expect_half(input logic [K*W-1:0] a, input logic [K*W-1:0] b, input logic hi);
    int v [2*K];
    logic [K*W-1:0] r;
    for (int s = 0; s < K; s++) begin
      v[s]     = int'(a[s*W +: W]);
      v[K + s] = int'(b[s*W +: W]);
    end
    for (int i = 1; i < 2*K; i++)
      for (int j = i; j > 0 && v[j-1] > v[j]; j--) begin
        int t = v[j]; v[j] = v[j-1]; v[j-1] = t;
      end
    for (int s = 0; s < K; s++) r[s*W +: W] = W'(v[hi ? K + s : s]);
    return r;
  endfunction

  // R1 R2 R3 R4 R5 R6 R8
  task automatic run(input logic [K*W-1:0] a, input logic [K*W-1:0] b, input logic hi, input bit disturb);
    int cnt = 0;
    logic [K*W-1:0] exp = expect_half(a, b, hi);
    logic [K*W-1:0] held;
    loc = a; rcv = b; role = hi; start = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      if (disturb && cnt == 2) begin
        start = 1'b1; loc = ~a; rcv = ~b; role = ~hi;
      end
    end while (!done && cnt < 20);
    start = 1'b0;
    check(cnt == K + 1, "R4/R6 done timing", cnt, K + 1);
    check(res == exp, hi ? "R3/R8/R6 high half" : "R2/R8/R6 low half", res, exp);
    held = res;
    @(negedge clk);
    check(!done && res == held, "R5/R4 hold and single done", {done, res}, {1'b0, held});
  endtask

  task automatic run5(input logic hi, input logic [19:0] exp);
    int cnt = 0;
    loc5 = {4'd13, 4'd11, 4'd8, 4'd6, 4'd1};
    rcv5 = {4'd12, 4'd10, 4'd9, 4'd7, 4'd2};
    role5 = hi; start5 = 1'b1;
    do begin
      @(negedge clk);
      cnt++;
      start5 = 1'b0;
    end while (!done5 && cnt < 20);
    check(cnt == 6 && res5 == exp, "R9 worked example", res5, exp);
  endtask

  initial begin
    int n = 0;
    for (int a = 0; a < 4; a++)
      for (int b = a; b < 4; b++)
        for (int c = b; c < 4; c++)
          for (int d = c; d < 4; d++) begin
            blocks[n] = {2'(d), 2'(c), 2'(b), 2'(a)};
            n++;
          end
    repeat (3) @(negedge clk);
    check(!done && res == '0, "R7 reset state", {done, res}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!done && res == '0, "R7 idle after release", {done, res}, 0);

    run5(1'b0, {4'd8, 4'd7, 4'd6, 4'd2, 4'd1});
    run5(1'b1, {4'd13, 4'd12, 4'd11, 4'd10, 4'd9});

    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NB; j++)
        for (int h = 0; h < 2; h++)
          run(blocks[i], blocks[j], h[0], (i == j) || ((i + j) % 7 == 0));

    // R7: reset mid-walk clears result and done
    loc = blocks[34]; rcv = blocks[34]; role = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check(!done && res == '0, "R7 async clear", {done, res}, 0);
    @(negedge clk); rst_ni = 1'b1;
    run(blocks[3], blocks[20], 1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule